// File: doc/BRIEF.md
# Multi-Input Fixed-Point Accumulating Adder

This block adds up a stream of signed two's-complement fixed-point operands into a single result of fixed word length and binary-point position. Each operand comes with its own count of fraction bits, so successive operands may use different scalings. One operand is taken per clock through a valid/ready input, and a last flag closes the running sum.

Each operand is first converted to the output format. Operands with more fraction bits than the output are shifted right and rounded toward minus infinity. Operands with fewer fraction bits are shifted left, and a shift that drops significant bits counts as an overflow. The converted operand is then added to the accumulator, which is range-checked again. The overflow policy is a parameter: clamp to the nearest rail, or keep the low bits.

Rounding and range handling happen at every step, never once on the finished total. The reported sum can therefore differ from the exact sum of the real values. The result appears together with a sticky overflow flag one cycle after the closing operand, and the accumulator restarts from a configurable start value.

Top module: `fxacc_top`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_sum`, `out_ovf` and `in_ready` are all 0. From the first clock after reset is released, `in_ready` is 1 and stays 1.
- R2: Every sum starts from the parameter `BIAS`, which defaults to 0. A sum of one operand whose `in_frac` equals `OUT_FRAC` (default 3) returns that operand's code unchanged.
- R3: `in_frac` is an unsigned count of operand fraction bits. When `in_frac` > `OUT_FRAC`, the operand is arithmetically shifted right by the difference, which is a floor rounding, so negative values move toward minus infinity. This conversion never raises overflow.
- R4: When `in_frac` < `OUT_FRAC`, the operand is shifted left by the difference. If the shifted value does not fit in `OUT_W` signed bits, it overflows. With saturation (the default), it becomes the most positive code (0x7F at 8 bits) or the most negative code (0x80).
- R5: An addition overflows only when both addends have the same sign bit and the sum's sign bit differs from it. With saturation, the accumulator then holds 0x7F for positive overflow or 0x80 for negative overflow.
- R6: Adding two values of opposite sign never raises overflow.
- R7: Saturation is applied after each addition. For example, 100 + 100 − 100 (codes at 3 fraction bits) gives 27, not 100.
- R8: `out_valid` is high for exactly the one cycle after an operand with `in_last`=1 is accepted, with `out_sum` holding the final sum. The next operand starts a new sum from `BIAS`. Closing operands on consecutive cycles give results on consecutive cycles.
- R9: `out_ovf` is 1 if any conversion or addition in that sum overflowed, even if later steps did not. It starts at 0 again for the next sum.
- R10: Cycles with `in_valid`=0 leave the accumulator unchanged and produce no result, whatever `in_data`, `in_frac` and `in_last` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can accept an operand |
| in_data | input | IN_W | Operand code, signed two's complement |
| in_frac | input | FRAC_W | Number of fraction bits of the operand |
| in_last | input | 1 | Operand closes the current sum |
| out_valid | output | 1 | One-cycle result strobe |
| out_sum | output | OUT_W | Final sum, OUT_FRAC fraction bits |
| out_ovf | output | 1 | Some step of this sum overflowed |

## Verification
The bound checker checks the following on every cycle:
- a right-shifting conversion never flags overflow;
- overflowing left shifts and additions land on a rail;
- an addition overflow always has same-signed addends;
- an idle cycle leaves the accumulator alone;
- a closing operand restarts the accumulator and raises the result strobe;
- an overflow in the closing step reaches `out_ovf`.

Only the bench scenarios can show the actual numbers. These are floor rounding of negative operands, the gap against the exact sum in the mixed-scaling example, and clamping partway through a sum. They also cover stickiness across steps that do not overflow and the clean start of the following sum.

// File: rtl/fxacc_pkg.sv
package fxacc_pkg;
  typedef enum logic {
    OVF_WRAP = 1'b0,
    OVF_SAT  = 1'b1
  } ovf_mode_e;
endpackage

// File: rtl/fxacc_align.sv
module fxacc_align #(
  parameter int IN_W     = 8,
  parameter int OUT_W    = 8,
  parameter int OUT_FRAC = 3,
  parameter int FRAC_W   = 3,
  parameter fxacc_pkg::ovf_mode_e MODE = fxacc_pkg::OVF_SAT
) (
  input  logic [IN_W-1:0]   op_data,
  input  logic [FRAC_W-1:0] op_frac,
  output logic [OUT_W-1:0]  conv_val,
  output logic              conv_ovf,
  output logic              conv_right
);
  localparam int BASE_W = (IN_W + OUT_FRAC > OUT_W) ? IN_W + OUT_FRAC : OUT_W;
  localparam int WW     = BASE_W + 1;
  localparam logic [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

  // Re-scale the operand to OUT_FRAC fraction bits in a width that loses nothing.
  function automatic logic signed [WW-1:0] rescale(input logic [IN_W-1:0] d,
                                                   input logic [FRAC_W-1:0] f);
    logic signed [WW-1:0] w;
    int fi;
    w  = WW'(signed'(d));
    fi = int'(f);
    if (fi > OUT_FRAC) w = w >>> (fi - OUT_FRAC);
    else               w = w <<< (OUT_FRAC - fi);
    return w;
  endfunction

  // True when the upper bits are a pure sign extension of bit OUT_W-1.
  function automatic logic fits_out(input logic signed [WW-1:0] w);
    return (&w[WW-1:OUT_W-1]) | ~(|w[WW-1:OUT_W-1]);
  endfunction

  logic signed [WW-1:0] wide;

  always_comb begin
    wide       = rescale(op_data, op_frac);
    conv_ovf   = ~fits_out(wide);
    conv_right = int'(op_frac) > OUT_FRAC;
  end

  generate
    if (MODE == fxacc_pkg::OVF_SAT) begin : g_sat
      assign conv_val = conv_ovf ? (wide[WW-1] ? MINV : MAXV) : wide[OUT_W-1:0];
    end else begin : g_wrap
      assign conv_val = wide[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fxacc_satadd.sv
module fxacc_satadd #(
  parameter int OUT_W = 8,
  parameter fxacc_pkg::ovf_mode_e MODE = fxacc_pkg::OVF_SAT
) (
  input  logic [OUT_W-1:0] add_a,
  input  logic [OUT_W-1:0] add_b,
  output logic [OUT_W-1:0] add_sum,
  output logic             add_ovf
);
  localparam logic [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

  function automatic logic sign_clash(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

  logic [OUT_W-1:0] raw;

  always_comb begin
    raw     = add_a + add_b;
    add_ovf = sign_clash(add_a[OUT_W-1], add_b[OUT_W-1], raw[OUT_W-1]);
  end

  generate
    if (MODE == fxacc_pkg::OVF_SAT) begin : g_sat
      assign add_sum = add_ovf ? (add_a[OUT_W-1] ? MINV : MAXV) : raw;
    end else begin : g_wrap
      assign add_sum = raw;
    end
  endgenerate
endmodule

// File: rtl/fxacc_top.sv
module fxacc_top #(
  parameter int IN_W     = 8,
  parameter int OUT_W    = 8,
  parameter int OUT_FRAC = 3,
  parameter int FRAC_W   = 3,
  parameter fxacc_pkg::ovf_mode_e OVF_MODE = fxacc_pkg::OVF_SAT,
  parameter logic [OUT_W-1:0] BIAS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_data,
  input  logic [FRAC_W-1:0] in_frac,
  input  logic              in_last,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_sum,
  output logic              out_ovf
);
  // Named internal events, used by the bound checker.
  logic             accept;
  logic [OUT_W-1:0] acc_q;
  logic             sticky_q;
  logic [OUT_W-1:0] conv_val;
  logic             conv_ovf;
  logic             conv_right;
  logic [OUT_W-1:0] sum_next;
  logic             add_ovf;
  logic             step_ovf;

  assign accept   = in_valid & in_ready;
  assign step_ovf = conv_ovf | add_ovf;

  fxacc_align #(
    .IN_W(IN_W), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC), .FRAC_W(FRAC_W), .MODE(OVF_MODE)
  ) u_align (
    .op_data   (in_data),
    .op_frac   (in_frac),
    .conv_val  (conv_val),
    .conv_ovf  (conv_ovf),
    .conv_right(conv_right)
  );

  fxacc_satadd #(
    .OUT_W(OUT_W), .MODE(OVF_MODE)
  ) u_add (
    .add_a  (acc_q),
    .add_b  (conv_val),
    .add_sum(sum_next),
    .add_ovf(add_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready  <= 1'b0;
      acc_q     <= BIAS;
      sticky_q  <= 1'b0;
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_ovf   <= 1'b0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= accept & in_last;
      if (accept) begin
        if (in_last) begin
          out_sum  <= sum_next;
          out_ovf  <= sticky_q | step_ovf;
          acc_q    <= BIAS;
          sticky_q <= 1'b0;
        end else begin
          acc_q    <= sum_next;
          sticky_q <= sticky_q | step_ovf;
        end
      end
    end
  end
endmodule

// File: rtl/fxacc_checker.sv
module fxacc_checker #(
  parameter int OUT_W    = 8,
  parameter int OUT_FRAC = 3,
  parameter int FRAC_W   = 3,
  parameter bit SAT      = 1'b1,
  parameter logic [OUT_W-1:0] BIAS = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              in_last,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ovf,
  input logic [OUT_W-1:0]  acc_q,
  input logic [OUT_W-1:0]  conv_val,
  input logic              conv_ovf,
  input logic              conv_right,
  input logic [OUT_W-1:0]  sum_next,
  input logic              add_ovf
);
  localparam logic [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && conv_right) |-> !conv_ovf);

  generate
    if (SAT) begin : g_sat
      assert_conv_rail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && conv_ovf) |-> (conv_val == MAXV || conv_val == MINV));
      assert_add_rail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && add_ovf) |-> (sum_next == MAXV || sum_next == MINV));
    end
  endgenerate

  assert_same_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    add_ovf |-> (acc_q[OUT_W-1] == conv_val[OUT_W-1]));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_last) |=> (out_valid && acc_q == BIAS));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_last && (conv_ovf || add_ovf)) |=> out_ovf);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(acc_q) && !out_valid));
endmodule

bind fxacc_top fxacc_checker #(
  .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC), .FRAC_W(FRAC_W),
  .SAT(OVF_MODE == fxacc_pkg::OVF_SAT), .BIAS(BIAS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .in_last(in_last),
  .in_ready(in_ready), .out_valid(out_valid), .out_ovf(out_ovf),
  .acc_q(acc_q), .conv_val(conv_val), .conv_ovf(conv_ovf),
  .conv_right(conv_right), .sum_next(sum_next), .add_ovf(add_ovf)
);

// File: tb/fxacc_top_tb.sv
module fxacc_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [2:0] in_frac = '0;
  logic       in_last = 1'b0;
  logic       out_valid;
  logic [7:0] out_sum;
  logic       out_ovf;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int lasts  = 0;
  bit done   = 1'b0;

  int    exp_sum_q[$];
  bit    exp_ovf_q[$];
  string exp_tag_q[$];

  int model_acc = 0;
  bit model_ovf = 1'b0;

  always #2.5 clk = ~clk;

  fxacc_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_frac(in_frac), .in_last(in_last),
    .out_valid(out_valid), .out_sum(out_sum), .out_ovf(out_ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Clamp to the signed 8-bit range; report whether clamping happened.
  function automatic int clamp8(input int v, inout bit o);
    if (v > 127)  begin o = 1'b1; return 127;  end
    if (v < -128) begin o = 1'b1; return -128; end
    return v;
  endfunction

  // Driver: apply one operand and advance the reference model.
  task automatic send(input int code, input int frac, input bit last, input string tag);
    int v;
    int d;
    int r;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = code[7:0];
    in_frac  = frac[2:0];
    in_last  = last;
    v = int'(signed'(code[7:0]));
    if (frac > 3) begin
      d = 1 << (frac - 3);
      r = ((v % d) + d) % d;
      v = (v - r) / d;
    end else begin
      v = v * (1 << (3 - frac));
    end
    v = clamp8(v, model_ovf);
    model_acc = clamp8(model_acc + v, model_ovf);
    if (last) begin
      exp_sum_q.push_back(model_acc);
      exp_ovf_q.push_back(model_ovf);
      exp_tag_q.push_back(tag);
      lasts++;
      model_acc = 0;
      model_ovf = 1'b0;
    end
  endtask

  task automatic idle(input int n, input int junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = junk[7:0];
      in_frac  = 3'd7;
      in_last  = 1'b1;
    end
  endtask

  // Monitor: pop expected results as the design delivers them.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      pulses++;
      if (exp_sum_q.size() == 0) begin
        check(1'b0, "R8 unexpected out_valid", 1, 0);
      end else begin
        int    es;
        bit    eo;
        string t;
        es = exp_sum_q.pop_front();
        eo = exp_ovf_q.pop_front();
        t  = exp_tag_q.pop_front();
        check(out_sum == es[7:0], {t, " sum"}, int'(signed'(out_sum)), es);
        check(out_ovf == eo, {t, " ovf"}, int'(out_ovf), int'(eo));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(out_sum == 8'd0, "R1 out_sum", int'(out_sum), 0);
    check(out_ovf == 1'b0, "R1 out_ovf", int'(out_ovf), 0);
    check(in_ready == 1'b0, "R1 in_ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R2 single operand at matching scale
    send(40, 3, 1'b1, "R2 single");
    // R3/R7 mixed scaling: 5.875, 5.4375, 2.84375 -> 112 (14.0), below exact 14.15625
    send(47, 3, 1'b0, "R3 mixed");
    send(87, 4, 1'b0, "R3 mixed");
    send(91, 5, 1'b1, "R3 mixed");
    // R3 negative floor: -1@4 -> -1, -3@5 -> -1, total -2
    send(-1, 4, 1'b0, "R3 negfloor");
    send(-3, 5, 1'b1, "R3 negfloor");
    // R4 left shift without and with loss
    send(5, 1, 1'b0, "R4 left");
    send(3, 0, 1'b1, "R4 left");
    send(100, 0, 1'b1, "R4 left overflow");
    send(-100, 0, 1'b1, "R4 left neg overflow");
    // R5 addition overflow both rails
    send(100, 3, 1'b0, "R5 pos");
    send(100, 3, 1'b1, "R5 pos");
    send(-100, 3, 1'b0, "R5 neg");
    send(-100, 3, 1'b1, "R5 neg");
    // R6 opposite signs at the extremes
    send(127, 3, 1'b0, "R6 mixed sign");
    send(-128, 3, 1'b1, "R6 mixed sign");
    // R7 per-step saturation: 100+100-100 -> 27
    send(100, 3, 1'b0, "R7 step sat");
    send(100, 3, 1'b0, "R7 step sat");
    send(-100, 3, 1'b1, "R7 step sat");
    // R9 sticky flag then clean next sum
    send(100, 3, 1'b0, "R9 sticky");
    send(100, 3, 1'b0, "R9 sticky");
    send(-100, 3, 1'b0, "R9 sticky");
    send(-50, 3, 1'b1, "R9 sticky");
    send(10, 3, 1'b1, "R9 cleared");
    // R10 idle cycles carrying junk and last=1 inside a sum
    send(8, 3, 1'b0, "R10 idle");
    idle(3, 99);
    send(8, 3, 1'b1, "R10 idle");
    // R8 back-to-back closing operands
    send(1, 0, 1'b1, "R8 b2b");
    send(2, 0, 1'b1, "R8 b2b");
    send(3, 0, 1'b1, "R8 b2b");
    idle(5, 55);
    check(exp_sum_q.size() == 0, "R8 all results delivered", exp_sum_q.size(), 0);
    check(pulses == lasts, "R8 one pulse per last", pulses, lasts);
    check(out_valid == 1'b0, "R10 no result while idle", int'(out_valid), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule